// File: doc/BRIEF.md
# Tile-Triggered Pattern Bank Switch

This block sits on the graphics-side address bus of a tile renderer. It remaps the two 4 KB halves of the pattern-table space onto a larger character ROM. Each half has a one-bit state that picks one of two 5-bit bank registers. The state flips when the renderer fetches the upper bit-plane byte of one of two marker tiles, `0xFD` and `0xFE`. This lets a background or sprite layer swap its tile set partway across a scanline without any CPU work.

The CPU side loads the four bank registers through one-hot write strobes that carry shared 5-bit data. Address decoding of those writes lies outside the block.

The two halves match marker fetches differently:
- The upper half (`0x1000`–`0x1FFF`) reacts to every row of a marker tile.
- The lower half (`0x0000`–`0x0FFF`) reacts only to the top row.

A matching fetch finishes with the bank that was already selected. The new state is committed when the read strobe goes low.

Top module: `tile_bank_switch`

## Requirements
- R1: After reset both half states select their `0xFE` register, and all four bank registers are zero.
- R2: A read of `0x0FD8` switches the lower half to its `0xFD` register. A read of `0x0FE8` switches it back to its `0xFE` register.
- R3: Lower-half reads of the marker tiles at any row other than the top (for example `0x0FE9`, `0x0FEF`) leave the lower state unchanged.
- R4: Any read in `0x1FD8`–`0x1FDF` switches the upper half to its `0xFD` register. Any read in `0x1FE8`–`0x1FEF` switches it to its `0xFE` register.
- R5: The state commits on the first clock edge where the read strobe is sampled low after being high. The matching read itself, over all its cycles, is served with the previous bank.
- R6: Address bit 12 picks the half. The lower half uses only the state of the lower half, and the upper half uses only the state of the upper half. A trigger in one half does not change the other half.
- R7: `chr_addr_o[16:12]` carries the selected bank register, and `chr_addr_o[11:0]` equals `gfx_addr_i[11:0]`.
- R8: `bank_wr_i` bits map to registers as follows: bit 0 is lower/`0xFD`, bit 1 is lower/`0xFE`, bit 2 is upper/`0xFD`, bit 3 is upper/`0xFE`. A register loads `bank_data_i` on the clock edge where its strobe is high. The new value takes effect on the next read, whatever the current state.
- R9: A marker address presented while `gfx_rd_i` is low does not change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gfx_addr_i | input | 13 | Graphics pattern address |
| gfx_rd_i | input | 1 | Graphics read strobe |
| bank_wr_i | input | 4 | One-hot bank register write strobes |
| bank_data_i | input | 5 | Bank register write data |
| chr_addr_o | output | 17 | Character ROM address |

## Verification
A state commit and a bank register write can land on the same clock edge. The bench provokes this by raising a write strobe to the lower `0xFD` register in the cycle where the read strobe of a `0x0FD8` fetch drops. The next lower-half read must then return the freshly written value, which shows that both the new state and the new register took effect together. A second case writes the register that is not currently selected and checks that the output does not move until a trigger selects it.

// File: rtl/pbl_pkg.sv
package pbl_pkg;
  localparam int unsigned BANK_W  = 5;
  localparam int unsigned WIN_W   = 12;
  localparam int unsigned GADDR_W = WIN_W + 1;
  localparam int unsigned CHR_W   = BANK_W + WIN_W;
  localparam int unsigned NUM_HALF = 2;
  localparam int unsigned NUM_REG  = 2 * NUM_HALF;
  localparam int unsigned ROW_W    = 3;

  localparam logic [7:0] TILE_FD = 8'hFD;
  localparam logic [7:0] TILE_FE = 8'hFE;

  // state encoding doubles as the low bit of the register index
  typedef enum logic {
    LAT_FD = 1'b0,
    LAT_FE = 1'b1
  } lat_e;
endpackage

// File: rtl/pbl_match.sv
module pbl_match
  import pbl_pkg::*;
#(
  parameter logic HALF    = 1'b0,
  parameter bit   ROW_ANY = 1'b0
) (
  input  logic [GADDR_W-1:0] addr_i,
  output logic               hit_fd_o,
  output logic               hit_fe_o
);
  logic half_ok;
  logic plane_ok;
  logic row_ok;

  assign half_ok  = (addr_i[GADDR_W-1] == HALF);
  assign plane_ok = addr_i[ROW_W];

  generate
    if (ROW_ANY) begin : g_any_row
      assign row_ok = 1'b1;
    end else begin : g_top_row
      assign row_ok = (addr_i[ROW_W-1:0] == '0);
    end
  endgenerate

  assign hit_fd_o = half_ok && plane_ok && row_ok && (addr_i[WIN_W-1:ROW_W+1] == TILE_FD);
  assign hit_fe_o = half_ok && plane_ok && row_ok && (addr_i[WIN_W-1:ROW_W+1] == TILE_FE);
endmodule

// File: rtl/pbl_latch.sv
module pbl_latch
  import pbl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_i,
  input  logic hit_fd_i,
  input  logic hit_fe_i,
  output lat_e state_o
);
  logic rd_q;
  logic pend_vld_q;
  logic pend_fe_q;
  lat_e state_q;
  logic commit;

  assign commit = rd_q && !rd_i && pend_vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q       <= 1'b0;
      pend_vld_q <= 1'b0;
      pend_fe_q  <= 1'b0;
      state_q    <= LAT_FE;
    end else begin
      rd_q <= rd_i;
      if (rd_i) begin
        pend_vld_q <= hit_fd_i || hit_fe_i;
        pend_fe_q  <= hit_fe_i;
      end else begin
        pend_vld_q <= 1'b0;
      end
      if (commit) state_q <= pend_fe_q ? LAT_FE : LAT_FD;
    end
  end

  assign state_o = state_q;

  AST_HOLD_DURING_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> $stable(state_q)); // R5

  AST_COMMIT_ON_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_q && !rd_i && pend_vld_q) |=> (state_q == ($past(pend_fe_q) ? LAT_FE : LAT_FD))); // R2

  AST_IDLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !rd_q) |=> $stable(state_q)); // R9
endmodule

// File: rtl/pbl_bank_regs.sv
module pbl_bank_regs
  import pbl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_REG-1:0] wr_i,
  input  logic [BANK_W-1:0] data_i,
  output logic [BANK_W-1:0] banks_o [NUM_REG]
);
  for (genvar k = 0; k < NUM_REG; k++) begin : g_reg
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   bank_q <= '0;
      else if (wr_i[k]) bank_q <= data_i;
    end

    assign banks_o[k] = bank_q;

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i[k] |=> (bank_q == $past(data_i))); // R8
  end
endmodule

// File: rtl/pbl_bank_mux.sv
module pbl_bank_mux
  import pbl_pkg::*;
(
  input  logic [GADDR_W-1:0] addr_i,
  input  lat_e               state_i [NUM_HALF],
  input  logic [BANK_W-1:0]  banks_i [NUM_REG],
  output logic [CHR_W-1:0]   chr_addr_o
);
  logic                          half;
  logic [$clog2(NUM_REG)-1:0]    sel;

  always_comb begin
    half = addr_i[GADDR_W-1];
    sel  = {half, state_i[half]};
    chr_addr_o = {banks_i[sel], addr_i[WIN_W-1:0]};
  end
endmodule

// File: rtl/tile_bank_switch.sv
module tile_bank_switch
  import pbl_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [GADDR_W-1:0] gfx_addr_i,
  input  logic               gfx_rd_i,
  input  logic [NUM_REG-1:0] bank_wr_i,
  input  logic [BANK_W-1:0]  bank_data_i,
  output logic [CHR_W-1:0]   chr_addr_o
);
  lat_e              state [NUM_HALF];
  logic [BANK_W-1:0] banks [NUM_REG];

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    logic hit_fd;
    logic hit_fe;

    // lower half triggers on the top row only, upper half on every row
    pbl_match #(
      .HALF    (h[0]),
      .ROW_ANY (h != 0)
    ) u_match (
      .addr_i   (gfx_addr_i),
      .hit_fd_o (hit_fd),
      .hit_fe_o (hit_fe)
    );

    pbl_latch u_latch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_i     (gfx_rd_i),
      .hit_fd_i (hit_fd),
      .hit_fe_i (hit_fe),
      .state_o  (state[h])
    );
  end

  pbl_bank_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bank_wr_i),
    .data_i  (bank_data_i),
    .banks_o (banks)
  );

  pbl_bank_mux u_mux (
    .addr_i     (gfx_addr_i),
    .state_i    (state),
    .banks_i    (banks),
    .chr_addr_o (chr_addr_o)
  );

  AST_OUT_STABLE_IN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gfx_rd_i && $past(gfx_rd_i) && $stable(gfx_addr_i) && ($past(bank_wr_i) == '0))
      |-> $stable(chr_addr_o)); // R5

  AST_WINDOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(gfx_addr_i[WIN_W-1:0]) |-> $stable(chr_addr_o[WIN_W-1:0])); // R7

  AST_STATE_AFTER_RESET: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (state[0] == LAT_FE && state[1] == LAT_FE)); // R1
endmodule

// File: tb/tile_bank_switch_bench.sv
module tile_bank_switch_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] gfx_addr = '0;
  logic        gfx_rd = 1'b0;
  logic [3:0]  bank_wr = '0;
  logic [4:0]  bank_data = '0;
  logic [16:0] chr_addr;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    logic [16:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  // reference model
  logic [4:0] m_reg [4];
  logic       m_lat [2];   // 1 = FE state

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_bank_switch u_tile_bank_switch (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .gfx_addr_i  (gfx_addr),
    .gfx_rd_i    (gfx_rd),
    .bank_wr_i   (bank_wr),
    .bank_data_i (bank_data),
    .chr_addr_o  (chr_addr)
  );

  function automatic logic [16:0] model_addr(logic [12:0] a);
    logic h;
    h = a[12];
    return {m_reg[{h, m_lat[h]}], a[11:0]};
  endfunction

  function automatic void model_trigger(logic [12:0] a);
    if (a == 13'h0FD8) m_lat[0] = 1'b0;
    if (a == 13'h0FE8) m_lat[0] = 1'b1;
    if (a >= 13'h1FD8 && a <= 13'h1FDF) m_lat[1] = 1'b0;
    if (a >= 13'h1FE8 && a <= 13'h1FEF) m_lat[1] = 1'b1;
  endfunction

  // driver: one read of ncyc cycles, optional write on the strobe-drop cycle
  task automatic read_op(input logic [12:0] a, input int ncyc, input string tag,
                         input logic [3:0] wr = '0, input logic [4:0] wd = '0);
    item_t it;
    for (int i = 0; i < ncyc; i++) begin
      @(posedge clk); #1;
      gfx_addr = a;
      gfx_rd   = 1'b1;
      it.exp = model_addr(a);
      it.tag = tag;
      sb_q.push_back(it);
    end
    @(posedge clk); #1;
    gfx_rd    = 1'b0;
    bank_wr   = wr;
    bank_data = wd;
    model_trigger(a);
    for (int k = 0; k < 4; k++) if (wr[k]) m_reg[k] = wd;
    if (wr != '0) begin
      @(posedge clk); #1;
      bank_wr = '0;
    end
  endtask

  task automatic write_reg(input int k, input logic [4:0] d);
    @(posedge clk); #1;
    bank_wr   = 4'b0001 << k;
    bank_data = d;
    @(posedge clk); #1;
    bank_wr = '0;
    m_reg[k] = d;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && gfx_rd && sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (chr_addr !== it.exp) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", it.tag, chr_addr, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 4; k++) m_reg[k] = '0;
    m_lat[0] = 1'b1;
    m_lat[1] = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    read_op(13'h0123, 1, "R1 reset lower");
    read_op(13'h1456, 1, "R1 reset upper");

    // R8 load registers, R6/R7 selection by half
    write_reg(0, 5'h03);
    write_reg(1, 5'h11);
    write_reg(2, 5'h0A);
    write_reg(3, 5'h1F);
    read_op(13'h0456, 1, "R7 lower FE bank");
    read_op(13'h1ABC, 1, "R6 upper FE bank");

    // R5 trigger read served with old bank over several cycles; R2 switch
    read_op(13'h0FD8, 3, "R5 trigger uses old bank");
    read_op(13'h0100, 1, "R2 lower now FD");
    read_op(13'h1000, 1, "R6 upper unaffected");

    // R3 non-top rows and other plane in lower half
    read_op(13'h0FE9, 1, "R3 row1 read");
    read_op(13'h0FEF, 1, "R3 row7 read");
    read_op(13'h0FE0, 1, "R3 low plane read");
    read_op(13'h0100, 1, "R3 lower still FD");
    read_op(13'h0FE8, 1, "R2 FE trigger old bank");
    read_op(13'h0100, 1, "R2 lower back to FE");

    // R4 every row of the upper range
    for (int r = 0; r < 8; r++) begin
      read_op(13'h1FD8 + 13'(r), 1, "R4 FD row trigger");
      read_op(13'h1200, 1, "R4 upper after FD");
      read_op(13'h1FE8 + 13'(r), 1, "R4 FE row trigger");
      read_op(13'h1200, 1, "R4 upper after FE");
    end
    read_op(13'h0300, 1, "R6 lower unaffected by upper");

    // R9 marker on bus without read strobe
    @(posedge clk); #1;
    gfx_addr = 13'h0FD8;
    repeat (3) @(posedge clk);
    #1 gfx_addr = 13'h1FDB;
    repeat (3) @(posedge clk);
    read_op(13'h0100, 1, "R9 lower unchanged");
    read_op(13'h1100, 1, "R9 upper unchanged");

    // R8 write of selected and unselected registers
    write_reg(1, 5'h07);
    read_op(13'h0200, 1, "R8 selected reg write");
    write_reg(0, 5'h15);
    read_op(13'h0200, 1, "R8 unselected reg no effect");

    // R5/R8 commit and write on the same edge
    read_op(13'h0FD8, 2, "R5 collide trigger", 4'b0001, 5'h19);
    read_op(13'h0300, 1, "R8 collide new reg and state");
    read_op(13'h1FEA, 1, "R4 upper mid row");
    read_op(13'h1FFF, 1, "R7 upper window pass");

    @(posedge clk); #1;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R5 scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule